// File: doc/BRIEF.md
# Inter-dimensional Twiddle and Transpose Stage

This block sits between the two 16-point passes of a 256-point transform that is split 16×16. The first pass produces one 16-point result for each input column `l`. This block gathers a complete frame of those 256 complex results and multiplies each one by the inter-dimensional factor W256^(s·l) = exp(−j·2π·s·l/256). It then streams the products out in transposed order, so that the second pass receives, for each `s`, the sixteen values over `l` that it transforms.

Storage has two banks. One frame can be written while the previous one is read out, so with no stalls the block moves one sample per clock on each side without gaps. Both sides use a valid/ready handshake. A transfer happens on a rising clock edge where valid and ready are both high.

- Input back-pressure: `in_ready` is low only while both banks hold frames that are not yet fully read.
- Output back-pressure: while `out_valid` is high and `out_ready` is low, the output sample is held and the read pipeline stalls.
- Frame-start markers: `in_sof` realigns the input count. `out_sof` marks the first sample of every output frame.

Top module: `twx_stage`

## Requirements
- R1: Input sample number `i` of a frame (counted from 0) is the first-pass result with column `l = i / 16` and row `s = i % 16`. An accepted sample with `in_sof` high becomes number 0 of the frame being collected, and any partly collected samples before it are discarded.
- R2: Output sample number `o` of a frame is built from the input at `s = o / 16`, `l = o % 16`, so that all sixteen `l` values for one `s` leave together in increasing `l`.
- R3: A sample with `s·l ≠ 0` is multiplied by the complex coefficient `cr + j·ci`, where `cr = round(cos(2π·s·l/256)·2^(COEF_W−1))` and `ci = round(−sin(2π·s·l/256)·2^(COEF_W−1))`. Rounding is to nearest, with halves going away from zero, and each part is clipped to the signed COEF_W range.
- R4: For the full product `P`, the output part is `floor((P + 2^(COEF_W−2)) / 2^(COEF_W−1))`, saturated to the signed DATA_W range [−2^(DATA_W−1), 2^(DATA_W−1)−1].
- R5: A sample with `s = 0` or `l = 0` leaves unchanged, with the same latency as a multiplied sample.
- R6: `out_sof` is high on output sample 0 of each frame and low on all other output samples.
- R7: After reset `out_valid` is low, and it stays low until a complete 256-sample frame has been accepted.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sof`, `out_re` and `out_im` hold their values on the next clock.
- R9: After reset `in_ready` is high. Input is accepted while the previous frame is being read out. `in_ready` is low exactly when both banks hold unread frames.
- R10: With `in_valid` and `out_ready` held high, two back-to-back frames are accepted without `in_ready` dropping, and their 512 outputs appear on 512 consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take the input sample |
| in_sof | input | 1 | Input sample is number 0 of a frame |
| in_re | input | DATA_W | Real part of the input, two's complement |
| in_im | input | DATA_W | Imaginary part of the input, two's complement |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output sample |
| out_sof | output | 1 | Output sample is number 0 of a frame |
| out_re | output | DATA_W | Real part of the output, two's complement |
| out_im | output | DATA_W | Imaginary part of the output, two's complement |

## Verification
Two operations can fall in the same cycle: writing a new frame into one bank and reading the transposed previous frame from the other. In particular, the clock that releases a bank after its last read can coincide with the writer filling the other bank. The bench provokes this with back-to-back frames, and separately with random input gaps and output stalls. It also holds `out_ready` low until both banks fill, checks that `in_ready` falls and that pending input is held off, and then lets both frames drain. Every output handshake is compared against a behavioural model that rebuilds each frame from the accepted inputs, so any write that corrupts a bank still being read shows up as a value or order mismatch.

// File: rtl/twx_pkg.sv
package twx_pkg;

  localparam real TWX_PI = 3.141592653589793;

  // Coefficient part for exponent e of an n-point twiddle, scaled by 2^(cw-1).
  // want_im=0 gives cos, want_im=1 gives -sin. Evaluated at elaboration only.
  function automatic int twx_coef(input int e, input int n, input int cw, input bit want_im);
    real th;
    real x2;
    real term;
    real acc;
    real v;
    int  r;
    int  lim;
    th = 2.0 * TWX_PI * real'(e) / real'(n);
    if (th > TWX_PI) th = th - 2.0 * TWX_PI;
    x2 = th * th;
    if (!want_im) begin
      term = 1.0;
      acc  = 1.0;
      for (int k = 1; k < 24; k++) begin
        term = -term * x2 / real'((2 * k - 1) * (2 * k));
        acc  = acc + term;
      end
    end else begin
      term = th;
      acc  = th;
      for (int k = 1; k < 24; k++) begin
        term = -term * x2 / real'((2 * k) * (2 * k + 1));
        acc  = acc + term;
      end
      acc = -acc;
    end
    v = acc * real'(1 << (cw - 1));
    if (v >= 0.0) r = $rtoi(v + 0.5);
    else          r = -$rtoi(-v + 0.5);
    lim = 1 << (cw - 1);
    if (r > lim - 1) r = lim - 1;
    if (r < -lim)    r = -lim;
    return r;
  endfunction

endpackage

// File: rtl/twx_frame_buf.sv
module twx_frame_buf #(
  parameter int DATA_W = 8,
  parameter int AW     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic                     wr_sof,
  input  logic signed [DATA_W-1:0] wr_re,
  input  logic signed [DATA_W-1:0] wr_im,
  input  logic                     rd_en,
  input  logic [AW-1:0]            rd_addr,
  input  logic                     rd_last,
  output logic                     rd_avail,
  output logic signed [DATA_W-1:0] rd_re,
  output logic signed [DATA_W-1:0] rd_im
);
  localparam int FRAME = 1 << AW;
  localparam int WW    = 2 * DATA_W;

  logic [1:0]    full;
  logic          wsel;
  logic          rsel;
  logic          rsel_d;
  logic [AW-1:0] wr_cnt;
  logic [AW-1:0] wr_idx;
  logic          acc;
  logic [WW-1:0] rd_word;

  assign wr_ready = !full[wsel];
  assign acc      = wr_valid && wr_ready;
  assign wr_idx   = wr_sof ? '0 : wr_cnt;
  assign rd_avail = full[rsel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 2'b00;
      wsel   <= 1'b0;
      rsel   <= 1'b0;
      rsel_d <= 1'b0;
      wr_cnt <= '0;
    end else begin
      if (acc) begin
        if (wr_idx == {AW{1'b1}}) begin
          full[wsel] <= 1'b1;
          wsel       <= !wsel;
          wr_cnt     <= '0;
        end else begin
          wr_cnt <= wr_idx + 1'b1;
        end
      end
      if (rd_last) begin
        full[rsel] <= 1'b0;
        rsel       <= !rsel;
      end
      if (rd_en) rsel_d <= rsel;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WW-1:0] mem [FRAME];
    logic [WW-1:0] q;
    always_ff @(posedge clk) begin
      if (acc && (wsel == 1'(b))) mem[wr_idx] <= {wr_re, wr_im};
      if (rd_en) q <= mem[rd_addr];
    end
  end

  assign rd_word = rsel_d ? g_bank[1].q : g_bank[0].q;
  assign rd_re   = rd_word[WW-1:DATA_W];
  assign rd_im   = rd_word[DATA_W-1:0];

  // R9: with one bank holding a frame, reader and writer sit on different banks
  a_r9_bank_order: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(full) == 1) |-> (wsel != rsel && full[rsel]));

  // R1: a start marker makes the accepted sample number 0
  a_r1_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_sof) |=> (wr_cnt == AW'(1)));

endmodule

// File: rtl/twx_read_seq.sv
module twx_read_seq #(
  parameter int LW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            avail,
  output logic            issue,
  output logic            last,
  output logic [2*LW-1:0] addr,
  output logic [2*LW-1:0] expo,
  output logic            bypass,
  output logic            first
);
  localparam int AW = 2 * LW;

  logic [AW-1:0] cnt;
  logic [LW-1:0] s_i;
  logic [LW-1:0] l_i;

  assign s_i    = cnt[AW-1:LW];
  assign l_i    = cnt[LW-1:0];
  assign issue  = adv && avail;
  assign last   = issue && (cnt == {AW{1'b1}});
  assign addr   = {l_i, s_i};
  assign expo   = {{LW{1'b0}}, s_i} * {{LW{1'b0}}, l_i};
  assign bypass = (s_i == '0) || (l_i == '0);
  assign first  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (issue) cnt <= cnt + 1'b1;
  end

  // R2: read count moves only when a read is issued
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(cnt));

endmodule

// File: rtl/twx_coef_rom.sv
module twx_coef_rom #(
  parameter int LW     = 4,
  parameter int COEF_W = 10
) (
  input  logic [2*LW-1:0]          expo,
  output logic signed [COEF_W-1:0] c_re,
  output logic signed [COEF_W-1:0] c_im
);
  localparam int N     = 1 << (2 * LW);
  localparam int PM    = (1 << LW) - 1;
  localparam int DEPTH = PM * PM + 1;

  logic signed [COEF_W-1:0] t_re [DEPTH];
  logic signed [COEF_W-1:0] t_im [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam int VR = twx_pkg::twx_coef(g, N, COEF_W, 1'b0);
    localparam int VI = twx_pkg::twx_coef(g, N, COEF_W, 1'b1);
    assign t_re[g] = COEF_W'(VR);
    assign t_im[g] = COEF_W'(VI);
  end

  assign c_re = t_re[expo];
  assign c_im = t_im[expo];

endmodule

// File: rtl/twx_cmul_round.sv
module twx_cmul_round #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     i_valid,
  input  logic signed [DATA_W-1:0] i_re,
  input  logic signed [DATA_W-1:0] i_im,
  input  logic signed [COEF_W-1:0] c_re,
  input  logic signed [COEF_W-1:0] c_im,
  input  logic                     i_bypass,
  input  logic                     i_sof,
  output logic                     o_valid,
  output logic signed [DATA_W-1:0] o_re,
  output logic signed [DATA_W-1:0] o_im,
  output logic                     o_sof
);
  localparam int F  = COEF_W - 1;
  localparam int PW = DATA_W + COEF_W + 1;
  localparam logic signed [PW-1:0] HI   = PW'(2 ** (DATA_W - 1) - 1);
  localparam logic signed [PW-1:0] LO   = ~HI;
  localparam logic signed [PW-1:0] HALF = PW'(2 ** (F - 1));

  logic signed [PW-1:0] ar, ai, cr, ci;
  logic                 vb, byp_b, sof_b;
  logic signed [PW-1:0] pr_b, pi_b;
  logic signed [DATA_W-1:0] dr_b, di_b;

  assign ar = PW'(i_re);
  assign ai = PW'(i_im);
  assign cr = PW'(c_re);
  assign ci = PW'(c_im);

  function automatic logic signed [DATA_W-1:0] fit(input logic signed [PW-1:0] p);
    logic signed [PW-1:0] r;
    r = (p + HALF) >>> F;
    if (r > HI)      return HI[DATA_W-1:0];
    else if (r < LO) return LO[DATA_W-1:0];
    else             return r[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vb    <= 1'b0;
      byp_b <= 1'b0;
      sof_b <= 1'b0;
      pr_b  <= '0;
      pi_b  <= '0;
      dr_b  <= '0;
      di_b  <= '0;
    end else if (adv) begin
      vb    <= i_valid;
      byp_b <= i_bypass;
      sof_b <= i_sof;
      pr_b  <= ar * cr - ai * ci;
      pi_b  <= ar * ci + ai * cr;
      dr_b  <= i_re;
      di_b  <= i_im;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_sof   <= 1'b0;
      o_re    <= '0;
      o_im    <= '0;
    end else if (adv) begin
      o_valid <= vb;
      o_sof   <= vb && sof_b;
      o_re    <= byp_b ? dr_b : fit(pr_b);
      o_im    <= byp_b ? di_b : fit(pi_b);
    end
  end

  // R5: trivial-factor samples leave exactly as they came in
  a_r5_bypass_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && vb && byp_b) |=> (o_re == $past(dr_b) && o_im == $past(di_b)));

endmodule

// File: rtl/twx_stage.sv
module twx_stage #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 10,
  parameter int PTS    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_sof,
  input  logic signed [DATA_W-1:0] in_re,
  input  logic signed [DATA_W-1:0] in_im,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     out_sof,
  output logic signed [DATA_W-1:0] out_re,
  output logic signed [DATA_W-1:0] out_im
);
  localparam int LW = $clog2(PTS);
  localparam int AW = 2 * LW;

  logic                     adv, issue, last, avail, byp_i, first_i;
  logic [AW-1:0]            rd_addr;
  logic [AW-1:0]            expo;
  logic signed [DATA_W-1:0] rd_re, rd_im;
  logic signed [COEF_W-1:0] rom_re, rom_im;
  logic                     va, byp_a, sof_a;
  logic signed [COEF_W-1:0] ca_re, ca_im;

  assign adv = !out_valid || out_ready;

  twx_frame_buf #(.DATA_W(DATA_W), .AW(AW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(in_valid), .wr_ready(in_ready), .wr_sof(in_sof),
    .wr_re(in_re), .wr_im(in_im),
    .rd_en(adv), .rd_addr(rd_addr), .rd_last(last), .rd_avail(avail),
    .rd_re(rd_re), .rd_im(rd_im)
  );

  twx_read_seq #(.LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(adv), .avail(avail),
    .issue(issue), .last(last), .addr(rd_addr), .expo(expo),
    .bypass(byp_i), .first(first_i)
  );

  twx_coef_rom #(.LW(LW), .COEF_W(COEF_W)) u_rom (
    .expo(expo), .c_re(rom_re), .c_im(rom_im)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va    <= 1'b0;
      byp_a <= 1'b0;
      sof_a <= 1'b0;
      ca_re <= '0;
      ca_im <= '0;
    end else if (adv) begin
      va    <= issue;
      byp_a <= byp_i;
      sof_a <= first_i;
      ca_re <= rom_re;
      ca_im <= rom_im;
    end
  end

  twx_cmul_round #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .i_valid(va), .i_re(rd_re), .i_im(rd_im),
    .c_re(ca_re), .c_im(ca_im), .i_bypass(byp_a), .i_sof(sof_a),
    .o_valid(out_valid), .o_re(out_re), .o_im(out_im), .o_sof(out_sof)
  );

  // R8: a stalled output sample is held
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_sof)));

  // R6: the frame marker only rides on a valid sample
  a_r6_sof_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

endmodule

// File: tb/twx_stage_tb_top.sv
`timescale 1ns/1ps
module twx_stage_tb_top;
  localparam int DW = 8;
  localparam int CW = 10;
  localparam int FR = 256;
  localparam int F  = CW - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b0;
  logic signed [DW-1:0] in_re = '0, in_im = '0;
  logic in_ready, out_valid, out_sof;
  logic signed [DW-1:0] out_re, out_im;

  twx_stage #(.DATA_W(DW), .COEF_W(CW), .PTS(16)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
    .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof),
    .out_re(out_re), .out_im(out_im)
  );

  int checks = 0, fails = 0;
  int q_re[$], q_im[$];
  bit q_sof[$];
  int e_re[$], e_im[$];
  bit e_sof[$], e_byp[$];
  int fr_re[FR], fr_im[FR];
  int wcnt = 0, n_acc = 0, cyc = 0;
  int gap_pct = 0, stall_pct = 0;
  bit stall_all = 1'b0, track = 1'b0, pend = 1'b0, hold_p = 1'b0, finished = 1'b0;
  int in_block = 0, first_out = -1, last_out = -1;
  int h_re, h_im;
  bit h_sof;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd_r(input real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int clipi(input int v, input int lo, input int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // R3: coefficient model, R4: rounding and saturation model
  function automatic void build_expected();
    int s, l, xr, xi, e, cr, ci;
    longint pr, pim;
    real th;
    for (int o = 0; o < FR; o++) begin
      s  = o / 16;
      l  = o % 16;
      xr = fr_re[l * 16 + s];
      xi = fr_im[l * 16 + s];
      e  = s * l;
      if (e == 0) begin
        e_re.push_back(xr);
        e_im.push_back(xi);
        e_byp.push_back(1'b1);
      end else begin
        th  = 2.0 * 3.141592653589793 * real'(e) / 256.0;
        cr  = clipi(rnd_r($cos(th) * 512.0), -512, 511);
        ci  = clipi(rnd_r(-$sin(th) * 512.0), -512, 511);
        pr  = longint'(xr) * cr - longint'(xi) * ci;
        pim = longint'(xr) * ci + longint'(xi) * cr;
        e_re.push_back(clipi(int'((pr + 256) >>> F), -128, 127));
        e_im.push_back(clipi(int'((pim + 256) >>> F), -128, 127));
        e_byp.push_back(1'b0);
      end
      e_sof.push_back(o == 0);
    end
  endfunction

  task automatic model_accept(input int r, input int i, input bit sof);
    int idx;
    idx = sof ? 0 : wcnt;
    fr_re[idx] = r;
    fr_im[idx] = i;
    n_acc++;
    if (idx == FR - 1) begin
      build_expected();
      wcnt = 0;
    end else begin
      wcnt = idx + 1;
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (!pend) begin
      if (q_re.size() > 0 && $urandom_range(99) >= gap_pct) begin
        in_valid = 1'b1;
        in_re    = DW'(q_re[0]);
        in_im    = DW'(q_im[0]);
        in_sof   = q_sof[0];
      end else begin
        in_valid = 1'b0;
        in_sof   = 1'b0;
      end
    end
    out_ready = stall_all ? 1'b0 : ($urandom_range(99) >= stall_pct);
    #1;
    if (hold_p)
      chk(out_valid && out_re == h_re && out_im == h_im && out_sof == h_sof,
          "R8 output held under back-pressure", int'(out_re), h_re);
    if (track && in_valid && !in_ready) in_block++;
    if (in_valid && in_ready) begin
      model_accept(q_re[0], q_im[0], q_sof[0]);
      void'(q_re.pop_front());
      void'(q_im.pop_front());
      void'(q_sof.pop_front());
    end
    pend = in_valid && !in_ready;
    if (out_valid && out_ready) begin
      if (e_re.size() == 0) begin
        chk(1'b0, "R7 output before a full frame was collected", 1, 0);
      end else begin
        if (e_byp[0]) begin
          chk(out_re == e_re[0], "R2 R5 real part", int'(out_re), e_re[0]);
          chk(out_im == e_im[0], "R2 R5 imag part", int'(out_im), e_im[0]);
        end else begin
          chk(out_re == e_re[0], "R2 R3 R4 real part", int'(out_re), e_re[0]);
          chk(out_im == e_im[0], "R2 R3 R4 imag part", int'(out_im), e_im[0]);
        end
        chk(out_sof == e_sof[0], "R6 frame marker", int'(out_sof), int'(e_sof[0]));
        void'(e_re.pop_front());
        void'(e_im.pop_front());
        void'(e_sof.pop_front());
        void'(e_byp.pop_front());
      end
      if (track) begin
        if (first_out < 0) first_out = cyc;
        last_out = cyc;
      end
    end
    hold_p = out_valid && !out_ready;
    h_re   = int'(out_re);
    h_im   = int'(out_im);
    h_sof  = out_sof;
    cyc++;
  endtask

  task automatic push_frame(input int kind);
    int r, i;
    for (int n = 0; n < FR; n++) begin
      case (kind)
        0: begin r = ((n * 7) % 256) - 128; i = 100 - ((n * 3) % 201); end
        1: begin r = $urandom_range(255) - 128; i = $urandom_range(255) - 128; end
        default: begin
          r = $urandom_range(1) ? 127 : -128;
          i = $urandom_range(1) ? 127 : -128;
        end
      endcase
      q_re.push_back(r);
      q_im.push_back(i);
      q_sof.push_back(n == 0);
    end
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((q_re.size() > 0 || e_re.size() > 0) && guard < 20000) begin
      step();
      guard++;
    end
    chk(guard < 20000, "R2 all queued frames delivered", guard, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 out_valid low in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R9 in_ready high after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R7 out_valid low after reset", int'(out_valid), 0);

    // R10: two back-to-back frames, no gaps, no stalls
    push_frame(0);
    push_frame(1);
    gap_pct = 0; stall_pct = 0; track = 1'b1;
    while (n_acc < FR - 1) step();
    chk(out_valid == 1'b0, "R7 no output before frame complete", int'(out_valid), 0);
    drain();
    track = 1'b0;
    chk(in_block == 0, "R10 input never refused", in_block, 0);
    chk(last_out - first_out + 1 == 2 * FR, "R10 outputs on consecutive clocks",
        last_out - first_out + 1, 2 * FR);

    // R4: full-scale values with gaps and stalls
    gap_pct = 30; stall_pct = 30;
    push_frame(2);
    push_frame(2);
    drain();

    // R1: a partial frame followed by a new start marker
    gap_pct = 10; stall_pct = 10;
    for (int n = 0; n < 100; n++) begin
      q_re.push_back($urandom_range(255) - 128);
      q_im.push_back($urandom_range(255) - 128);
      q_sof.push_back(n == 0);
    end
    push_frame(1);
    drain();

    // R9: both banks full under total back-pressure
    gap_pct = 0; stall_all = 1'b1;
    push_frame(1);
    push_frame(0);
    push_frame(1);
    for (int g = 0; g < 3000 && q_re.size() > FR; g++) step();
    repeat (20) step();
    chk(q_re.size() == FR, "R9 third frame held off while banks full", q_re.size(), FR);
    chk(in_ready == 1'b0, "R9 in_ready low with both banks full", int'(in_ready), 0);
    stall_all = 1'b0; stall_pct = 20;
    drain();

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule